// File: doc/BRIEF.md
# Four-level cell microcode ROM read path

This block models a mask-programmed microcode store in which every cell holds one of four levels instead of one bit. A level index of 0 means no device and 3 means the largest device. A read takes an 11-bit word address. The low eight bits pick one column of the cell array, through two half decoders: one serves the even columns and one serves the odd columns. The top three bits pick which of eight row lines feeds each of eight sense slices.

Each slice compares its level against three ordered thresholds, which gives a thermometer pattern. The slice holds that pattern in a latch once a programmable settling wait has passed, then maps it onto two data bits. The eight slices together return a 16-bit word.

The store is 1648 words deep. Addresses at or above that depth are flagged and return zero. The cell contents come from a parameter pattern of 2-bit level indices. A request is taken only when no read is in flight. The result is announced by a one-cycle valid pulse and stays on the outputs until the next result.

Top module: `mlc_rom_read`

## Requirements
- R1: While reset is asserted, and after it is released until the first result, valid_o, data_o, range_err_o and sense_err_o are all zero.
- R2: A word address a selects column a[7:0] and row group a[10:8]. The column decoder used is the even one when a[0]=0 and the odd one when a[0]=1. Slice s reads row line 8*s + a[10:8] of the selected column.
- R3: The cell read by slice s for word a holds level PAT[2k+1:2k], where k = (a + 3*s + (a>>5)) mod 16.
- R4: A slice forms its sense value as twice the level. Thermometer bit i is 1 when the sense value is strictly greater than threshold THi. The default thresholds are 1, 3 and 5, which give 000, 001, 011 and 111 for levels 0 to 3.
- R5: The latched thermometer code maps to data_o[2s+1:2s] as follows: 000 gives 00, 001 gives 01, 011 gives 11, 111 gives 10.
- R6: Any other thermometer pattern sets sense_err_o[s] and forces that slice's two bits to 00.
- R7: A request is accepted on a rising edge when no read is in flight. settle_i is sampled on that edge. valid_o is high for exactly one cycle, settle+1 rising edges after the accepting edge.
- R8: data_o, range_err_o and sense_err_o change only on the edge that raises valid_o, and hold between results.
- R9: A request made while a read is in flight is ignored. The result returned is that of the accepted address.
- R10: An address of DEPTH (default 1648) or more returns range_err_o=1, data_o=0 and sense_err_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Read request |
| addr_i | input | 11 | Word address |
| settle_i | input | 6 | Settling wait in cycles before the latch captures |
| valid_o | output | 1 | One-cycle pulse when a new word is latched |
| data_o | output | 16 | Latched and decoded word |
| range_err_o | output | 1 | Latched address was at or above the depth |
| sense_err_o | output | 8 | Per-slice non-monotonic thermometer flag |

## Verification
The hardest case to reach is the sense error. With ordered thresholds a non-monotonic thermometer pattern cannot occur, so no choice of address or timing drives that path in a normally built instance. The bench therefore builds a second instance whose upper two thresholds are swapped. That instance shares all inputs with the first. Every level-2 cell in it then produces the pattern 101, and the bench checks its per-slice flags and its zeroed bit pairs on every word of the full address sweep. The sweep also runs into the out-of-range tail. A read with a long settle is interrupted by extra requests to show that they are dropped.

// File: rtl/mlc_rom_pkg.sv
package mlc_rom_pkg;
  typedef logic [1:0] lvl_t;
  typedef logic [2:0] therm_t;

  // level stored at (column, row line) of the cell array
  function automatic lvl_t cell_level(logic [31:0] pat, int col, int row,
                                      int ncol, int groups);
    int a;
    int s;
    int k;
    a = (row % groups) * ncol + col;
    s = row / groups;
    k = (a + 3 * s + (a >> 5)) % 16;
    return lvl_t'(pat >> (2 * k));
  endfunction

  // returns {err, bits}; only monotonic codes are legal
  function automatic logic [2:0] therm_decode(therm_t t);
    case (t)
      3'b000:  return 3'b0_00;
      3'b001:  return 3'b0_01;
      3'b011:  return 3'b0_11;
      3'b111:  return 3'b0_10;
      default: return 3'b1_00;
    endcase
  endfunction
endpackage

// File: rtl/mlc_col_dec.sv
module mlc_col_dec #(
  parameter int COL_W  = 8,
  parameter bit PARITY = 1'b0
) (
  input  logic [COL_W-1:0]           col_i,
  output logic [(1<<(COL_W-1))-1:0]  sel_o
);
  localparam int HALF = 1 << (COL_W - 1);

  always_comb begin
    for (int j = 0; j < HALF; j++) begin
      sel_o[j] = (col_i[0] == PARITY) && (col_i[COL_W-1:1] == (COL_W-1)'(j));
    end
  end
endmodule

// File: rtl/mlc_sense_slice.sv
module mlc_sense_slice
  import mlc_rom_pkg::*;
#(
  parameter int GROUPS = 8,
  parameter int TH0    = 1,
  parameter int TH1    = 3,
  parameter int TH2    = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [GROUPS-1:0][1:0] lines_i,
  input  logic [GROUPS-1:0]      grp_sel_i,
  input  logic                   blank_i,
  input  logic                   latch_i,
  output logic [1:0]             bits_o,
  output logic                   err_o
);
  lvl_t   lvl;
  int     strength;
  therm_t therm, therm_q;
  logic [2:0] dec;

  always_comb begin
    lvl = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (grp_sel_i[g]) lvl = lvl | lines_i[g];
    end
  end

  always_comb begin
    strength = 2 * int'(lvl);
    therm[0] = strength > TH0;
    therm[1] = strength > TH1;
    therm[2] = strength > TH2;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      therm_q <= '0;
    else if (latch_i) therm_q <= blank_i ? '0 : therm;
  end

  assign dec    = therm_decode(therm_q);
  assign err_o  = dec[2];
  assign bits_o = dec[1:0];
endmodule

// File: rtl/mlc_rom_read.sv
module mlc_rom_read
  import mlc_rom_pkg::*;
#(
  parameter int          DEPTH    = 1648,
  parameter int          COL_W    = 8,
  parameter int          GRP_W    = 3,
  parameter int          SLICES   = 8,
  parameter int          SETTLE_W = 6,
  parameter logic [31:0] PAT      = 32'h9C63_E41B,
  parameter int          TH0      = 1,
  parameter int          TH1      = 3,
  parameter int          TH2      = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic [COL_W+GRP_W-1:0]     addr_i,
  input  logic [SETTLE_W-1:0]        settle_i,
  output logic                       valid_o,
  output logic [2*SLICES-1:0]        data_o,
  output logic                       range_err_o,
  output logic [SLICES-1:0]          sense_err_o
);
  localparam int ADDR_W = COL_W + GRP_W;
  localparam int NCOL   = 1 << COL_W;
  localparam int HALF   = NCOL / 2;
  localparam int GROUPS = 1 << GRP_W;
  localparam int ROWS   = SLICES * GROUPS;
  localparam int DATA_W = 2 * SLICES;

  logic                busy_q;
  logic [SETTLE_W-1:0] cnt_q, settle_q;
  logic [ADDR_W-1:0]   addr_q;
  logic                valid_q, rerr_q;
  logic                latch_en, oor;

  assign oor      = int'(addr_q) >= DEPTH;
  assign latch_en = busy_q && (cnt_q == settle_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      settle_q <= '0;
      addr_q   <= '0;
      valid_q  <= 1'b0;
      rerr_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (!busy_q) begin
        if (req_i) begin
          busy_q   <= 1'b1;
          cnt_q    <= '0;
          settle_q <= settle_i;
          addr_q   <= addr_i;
        end
      end else if (latch_en) begin
        busy_q  <= 1'b0;
        valid_q <= 1'b1;
        rerr_q  <= oor;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // split column decode: even and odd halves
  logic [1:0][HALF-1:0] half_sel;
  logic [NCOL-1:0]      col_sel;

  for (genvar p = 0; p < 2; p++) begin : g_coldec
    mlc_col_dec #(.COL_W(COL_W), .PARITY(p[0])) u_dec (
      .col_i (addr_q[COL_W-1:0]),
      .sel_o (half_sel[p])
    );
    for (genvar j = 0; j < HALF; j++) begin : g_map
      assign col_sel[2*j+p] = half_sel[p][j];
    end
  end

  logic [COL_W-1:0] col_idx;
  always_comb begin
    col_idx = '0;
    for (int c = 0; c < NCOL; c++) begin
      if (col_sel[c]) col_idx = col_idx | COL_W'(c);
    end
  end

  logic [ROWS-1:0][1:0] row_lvl;
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      row_lvl[r] = cell_level(PAT, int'(col_idx), r, NCOL, GROUPS);
    end
  end

  logic [GROUPS-1:0] grp_sel;
  always_comb begin
    for (int g = 0; g < GROUPS; g++) begin
      grp_sel[g] = addr_q[ADDR_W-1:COL_W] == GRP_W'(g);
    end
  end

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    mlc_sense_slice #(.GROUPS(GROUPS), .TH0(TH0), .TH1(TH1), .TH2(TH2)) u_slice (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lines_i   (row_lvl[s*GROUPS +: GROUPS]),
      .grp_sel_i (grp_sel),
      .blank_i   (oor),
      .latch_i   (latch_en),
      .bits_o    (data_o[2*s +: 2]),
      .err_o     (sense_err_o[s])
    );
  end

  assign valid_o     = valid_q;
  assign range_err_o = rerr_q;

  logic unused_ok;
  assign unused_ok = DATA_W > 0;
endmodule

// File: rtl/mlc_rom_read_chk.sv
module mlc_rom_read_chk #(
  parameter int SLICES = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_o,
  input logic [2*SLICES-1:0] data_o,
  input logic                range_err_o,
  input logic [SLICES-1:0]   sense_err_o,
  input logic                busy_i
);
  // R7
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R7
  valid_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(busy_i));

  // R9
  busy_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> valid_o);

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(data_o) && $stable(range_err_o) && $stable(sense_err_o)));

  // R10
  range_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    range_err_o |-> (data_o == '0 && sense_err_o == '0));

  for (genvar s = 0; s < SLICES; s++) begin : g_err
    // R6
    sense_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sense_err_o[s] |-> (data_o[2*s +: 2] == 2'b00));
  end
endmodule

bind mlc_rom_read mlc_rom_read_chk #(.SLICES(SLICES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_o     (valid_o),
  .data_o      (data_o),
  .range_err_o (range_err_o),
  .sense_err_o (sense_err_o),
  .busy_i      (busy_q)
);

// File: tb/sim_mlc_rom_read.sv
module sim_mlc_rom_read;
  localparam int          CLK_PERIOD = 10;
  localparam int          DEPTH      = 1648;
  localparam logic [31:0] PAT        = 32'h9C63_E41B;
  localparam int          WD_LIMIT   = 150000;

  logic        clk, rst_n, req;
  logic [10:0] addr;
  logic [5:0]  settle;
  logic        valid0, valid1, rerr0, rerr1;
  logic [15:0] data0, data1;
  logic [7:0]  serr0, serr1;

  mlc_rom_read #(.PAT(PAT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .settle_i(settle),
    .valid_o(valid0), .data_o(data0), .range_err_o(rerr0), .sense_err_o(serr0));

  // swapped upper thresholds: level 2 senses as 101
  mlc_rom_read #(.PAT(PAT), .TH1(5), .TH2(3)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .settle_i(settle),
    .valid_o(valid1), .data_o(data1), .range_err_o(rerr1), .sense_err_o(serr1));

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit cmp_on = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int lvl_of(int a, int s);
    int k;
    k = (a + 3 * s + (a >> 5)) % 16;
    return int'((PAT >> (2 * k)) & 32'h3);
  endfunction

  function automatic logic [15:0] exp_data(int a, bit bad);
    logic [15:0] d;
    d = '0;
    if (a >= DEPTH) return d;
    for (int s = 0; s < 8; s++) begin
      case (lvl_of(a, s))
        0: d[2*s +: 2] = 2'b00;
        1: d[2*s +: 2] = 2'b01;
        2: d[2*s +: 2] = bad ? 2'b00 : 2'b11;
        default: d[2*s +: 2] = 2'b10;
      endcase
    end
    return d;
  endfunction

  function automatic logic [7:0] exp_serr(int a, bit bad);
    logic [7:0] e;
    e = '0;
    if (a >= DEPTH || !bad) return e;
    for (int s = 0; s < 8; s++) e[s] = (lvl_of(a, s) == 2);
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model
  bit          m_busy, m_valid, m_rerr;
  int          m_cnt, m_st, m_addr;
  logic [15:0] m_data, m_data1;
  logic [7:0]  m_serr1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_valid <= 0; m_rerr <= 0; m_cnt <= 0; m_st <= 0; m_addr <= 0;
      m_data <= '0; m_data1 <= '0; m_serr1 <= '0;
    end else begin
      m_valid <= 0;
      if (!m_busy) begin
        if (req) begin
          m_busy <= 1; m_cnt <= 0; m_st <= int'(settle); m_addr <= int'(addr);
        end
      end else if (m_cnt == m_st) begin
        m_busy  <= 0;
        m_valid <= 1;
        m_rerr  <= m_addr >= DEPTH;
        m_data  <= exp_data(m_addr, 0);
        m_data1 <= exp_data(m_addr, 1);
        m_serr1 <= exp_serr(m_addr, 1);
      end else begin
        m_cnt <= m_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check(valid0 == m_valid && valid1 == m_valid, "R7 R9 valid timing", {valid1, valid0}, {m_valid, m_valid});
      check(data0 == m_data, "R2 R3 R4 R5 R8 data u0", data0, m_data);
      check(rerr0 == m_rerr && rerr1 == m_rerr, "R10 range flag", {rerr1, rerr0}, {m_rerr, m_rerr});
      check(serr0 == 8'h00, "R4 ordered thresholds no sense error", serr0, 0);
      check(data1 == m_data1 && serr1 == m_serr1, "R6 swapped-threshold slice", {serr1, data1}, {m_serr1, m_data1});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL R7 watchdog: cycles=%0d expected<%0d", cyc, WD_LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic do_read(input int a, input int st);
    @(negedge clk);
    while (m_busy) @(negedge clk);
    req = 1; addr = 11'(a); settle = 6'(st);
    @(negedge clk);
    req = 0;
    while (m_busy) @(negedge clk);
  endtask

  initial begin
    req = 0; addr = '0; settle = '0; rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!valid0 && data0 == 0 && !rerr0 && serr0 == 0, "R1 reset outputs u0", {valid0, rerr0, serr0, data0}, 0);
    check(!valid1 && data1 == 0 && !rerr1 && serr1 == 0, "R1 reset outputs u1", {valid1, rerr1, serr1, data1}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!valid0 && data0 == 0, "R1 after release", {valid0, data0}, 0);
    cmp_on = 1;

    // R2 R3 R5 R10 full sweep including the range tail
    for (int a = 0; a < 2048; a++) do_read(a, a % 3);

    // R7 latency with settle 7
    begin
      int n;
      @(negedge clk);
      req = 1; addr = 11'd300; settle = 6'd7; n = 0;
      do begin
        @(negedge clk); n++;
        if (n == 1) req = 0;
      end while (!valid0 && n < 100);
      check(n == 9, "R7 latency settle 7", n, 9);
    end

    // R9 requests during a read are dropped
    begin
      @(negedge clk);
      req = 1; addr = 11'd77; settle = 6'd12;
      @(negedge clk);
      req = 0;
      repeat (3) @(negedge clk);
      req = 1; addr = 11'd1234;
      repeat (3) @(negedge clk);
      req = 0;
      while (!valid0) @(negedge clk);
      check(data0 == exp_data(77, 0), "R9 ignored request keeps first address", data0, exp_data(77, 0));
    end

    // R8 outputs hold while idle inputs wiggle
    begin
      logic [15:0] held;
      held = data0;
      for (int i = 0; i < 6; i++) begin
        addr = 11'(i * 311); settle = 6'(i);
        @(negedge clk);
      end
      check(data0 == held, "R8 hold between results", data0, held);
    end

    // R6 explicit: find a word with a level-2 cell
    begin
      int a6;
      a6 = 0;
      while (exp_serr(a6, 1) == 0) a6++;
      do_read(a6, 2);
      check(serr1 == exp_serr(a6, 1) && serr1 != 0, "R6 non-monotonic flagged", serr1, exp_serr(a6, 1));
    end

    // R10 explicit, maximum settle
    do_read(2047, 63);
    check(rerr0 && data0 == 0, "R10 top address out of range", {rerr0, data0}, 17'h10000);
    do_read(DEPTH - 1, 63);
    check(!rerr0 && data0 == exp_data(DEPTH - 1, 0), "R10 last valid word", data0, exp_data(DEPTH - 1, 0));

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule